// File: doc/BRIEF.md
# L1 Line Coherence Controller (MESI, directory based)

This block is the coherence state machine for one line of a private L1 cache in a directory-based MESI system. Each clock it can accept one event. The event is either a processor access (load, instruction fetch, store, eviction) or a message from the network (invalidate, forwarded read, forwarded instruction read, forwarded exclusive read, data, exclusive data, acknowledgement, writeback acknowledgement). In response it moves the line between its stable states (absent, invalid, shared, exclusive, modified) and its transient states. It also raises one-cycle strobes. These strobes tell the surrounding controller which message to build, and whether the processor access hit or must be retried.

The transient states cover the protocol races. An invalidate can overtake the data for a read miss. A forwarded request or an invalidate can reach the line after it has started a writeback. Invalidation acknowledgements can arrive before or after the data of a write miss. A signed counter tracks the acknowledgements still owed. Tags, data arrays and the network are outside this block.

Top module: `l1_line_coh_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `line_state` is 0 (absent), `line_perm` is 0 (none), every strobe is low and `proto_err` is low.
- R2: Permission follows the state. Code 0 (none) applies to absent=0 and invalid=1. Code 1 (read-only) applies to shared=2 and exclusive=3. Code 2 (read-write) applies to modified=4. Code 3 (busy) applies to every transient state: wait-shared=5, wait-modified=6, upgrading=7, wait-shared-killed=8, writeback-modified=9, writeback-exclusive=10 and drain=11.
- R3: In absent or invalid, the responses are:
  - load (event 0) raises `req_gets` and goes to 5;
  - instruction fetch (event 1) raises `req_geti` and goes to 5;
  - store (event 2) raises `req_getx` and goes to 6;
  - invalidate (event 4) raises only `rsp_inv_ack` and keeps the state;
  - eviction (event 3) goes to absent with no strobe.
- R4: In shared, exclusive or modified, a load or fetch raises `load_hit` and keeps the state. A store in exclusive or modified raises `store_hit` only and ends in modified. A store in shared raises `req_upgrade` and goes to 7. An eviction in shared goes to invalid with no strobe.
- R5: In exclusive or modified, the responses are:
  - a forwarded exclusive read (event 5) raises `rsp_data_req` and goes to invalid;
  - a forwarded read (event 6) or forwarded fetch (event 7) raises `rsp_data_req` and `rsp_data_l2` and goes to shared;
  - an invalidate goes to invalid, raising `rsp_inv_ack` from exclusive or `rsp_data_l2` from modified.
- R6: An eviction in modified raises `req_putx` and goes to 9. An eviction in exclusive raises `req_putx` and goes to 10. A writeback ack (event 11) in 9 or 10 returns the line to invalid.
- R7: In 9 or 10, the responses are:
  - forwarded requests are answered as in R5;
  - an invalidate raises `rsp_data_l2` in 9 and `rsp_inv_ack` in 10;
  - in every case the line goes to drain (11).
  In drain, an invalidate raises `rsp_inv_ack` and stays, and the writeback ack goes to invalid.
- R8: In any transient state, a load, fetch, store or eviction raises only `recycle` and leaves the state unchanged.
- R9: In 5 or 8, the responses are:
  - an invalidate raises `rsp_inv_ack` and goes to 8;
  - data (event 8) that settles the count raises `load_hit` and ends in shared from 5 or invalid from 8;
  - data with `evt_from_l1` set also raises `unblk_shared` and ends the same way regardless of the count;
  - exclusive data (event 9) raises `load_hit` and `unblk_excl` and ends in exclusive.
- R10: A miss request clears the acknowledgement counter. Data and ack (event 10) subtract the signed `evt_cnt` from it, and the event settles when the result is zero. In 6, data that settles raises `store_hit` and `unblk_excl` and ends in modified; data that does not settle goes to 7. In 6 an ack that does not settle keeps the state. In 7 an ack that settles raises `store_hit` and `unblk_excl` and ends in modified.
- R11: An invalidate in 6 or 7 raises `rsp_inv_ack` and goes to 6.
- R12: An event not legal in the current state sets the sticky `proto_err`, leaves the state unchanged and raises no strobe. Illegal events include codes 12 to 15, a second settling ack in 6, and non-settling data in 5.
- R13: Strobes and state are registered. They reflect the event accepted on the previous rising edge and are low in any cycle after an edge with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_kind | input | 4 | Event code (see R3 to R12) |
| evt_from_l1 | input | 1 | Data came from a peer L1 |
| evt_cnt | input | CNT_W | Signed amount subtracted from the ack counter |
| line_state | output | 4 | Current state code |
| line_perm | output | 2 | Access permission code |
| req_gets | output | 1 | Send read request |
| req_geti | output | 1 | Send instruction read request |
| req_getx | output | 1 | Send exclusive read request |
| req_upgrade | output | 1 | Send upgrade request |
| req_putx | output | 1 | Send writeback with data |
| rsp_data_req | output | 1 | Send data to the requester |
| rsp_data_l2 | output | 1 | Send data to the shared L2 |
| rsp_inv_ack | output | 1 | Send invalidate acknowledgement |
| unblk_shared | output | 1 | Send unblock |
| unblk_excl | output | 1 | Send exclusive unblock |
| load_hit | output | 1 | Load or fetch completed |
| store_hit | output | 1 | Store completed |
| recycle | output | 1 | Processor event must be retried |
| proto_err | output | 1 | Sticky illegal-event flag |

## Verification
Assertions check the following every cycle:
- at most one request strobe is high;
- a writeback strobe only accompanies a writeback state;
- an exclusive unblock only lands in exclusive or modified;
- a store hit always comes with read-write permission;
- a recycle never moves the line;
- the error flag never clears, and the state is frozen when it rises;
- an idle edge leaves all strobes low.

The directed scenarios in the bench show the rest: the exact message set and end state of every transition, the ordering of the invalidate-before-data and writeback races, and the signed acknowledgement arithmetic when acks precede or follow data.

// File: rtl/coh_line_pkg.sv
// Package: shared types for the L1 line coherence controller.
// Assumes a 4-bit event code and a 4-bit state code visible at the ports.
package coh_line_pkg;

    typedef enum logic [3:0] {
        ST_ABSENT      = 4'd0,
        ST_INV         = 4'd1,
        ST_SHR         = 4'd2,
        ST_EXC         = 4'd3,
        ST_MOD         = 4'd4,
        ST_WAIT_S      = 4'd5,
        ST_WAIT_M      = 4'd6,
        ST_UPG         = 4'd7,
        ST_WAIT_S_KILL = 4'd8,
        ST_WB_MOD      = 4'd9,
        ST_WB_EXC      = 4'd10,
        ST_DRAIN       = 4'd11
    } line_st_e;

    typedef enum logic [3:0] {
        EV_LOAD      = 4'd0,
        EV_FETCH     = 4'd1,
        EV_STORE     = 4'd2,
        EV_EVICT     = 4'd3,
        EV_INVAL     = 4'd4,
        EV_FWD_EXCL  = 4'd5,
        EV_FWD_RD    = 4'd6,
        EV_FWD_FETCH = 4'd7,
        EV_DATA      = 4'd8,
        EV_DATA_EXCL = 4'd9,
        EV_ACK       = 4'd10,
        EV_WB_ACK    = 4'd11
    } evt_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_RD   = 2'd1,
        PM_RW   = 2'd2,
        PM_BUSY = 2'd3
    } perm_e;

    // strobe bit positions inside the strobe vector
    localparam int NSTRB   = 13;
    localparam int SB_GETS = 12;
    localparam int SB_GETI = 11;
    localparam int SB_GETX = 10;
    localparam int SB_UPG  = 9;
    localparam int SB_PUTX = 8;
    localparam int SB_DREQ = 7;
    localparam int SB_DL2  = 6;
    localparam int SB_IACK = 5;
    localparam int SB_UNB  = 4;
    localparam int SB_XUNB = 3;
    localparam int SB_LHIT = 2;
    localparam int SB_SHIT = 1;
    localparam int SB_RCY  = 0;

    typedef struct packed {
        logic [NSTRB-1:0] strb;
        logic             err;
        logic             clr_cnt;
        logic             upd_cnt;
    } step_t;

endpackage

// File: rtl/coh_ack_tracker.sv
// Module: signed count of invalidation acks still owed for an open miss.
// Assumes clr and upd are already qualified by an accepted event.
module coh_ack_tracker #(
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    upd,
    input  logic signed [CNT_W-1:0] cnt,
    output logic                    settle
);
    logic signed [CNT_W-1:0] owed_q;
    logic signed [CNT_W-1:0] owed_d;

    // remainder after subtracting the incoming amount
    always_comb begin
        owed_d = owed_q - cnt;
        settle = (owed_d == '0);
    end

    // hold the remainder between events
    always_ff @(posedge clk) begin
        if (!rst_n)   owed_q <= '0;
        else if (clr) owed_q <= '0;
        else if (upd) owed_q <= owed_d;
    end

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (owed_q == '0));

endmodule

// File: rtl/coh_perm_map.sv
// Module: maps a line state to its access permission code.
// Assumes every state not stable is a busy transient.
module coh_perm_map
    import coh_line_pkg::*;
(
    input  line_st_e st,
    output perm_e    perm
);
    // decode permission from state
    always_comb begin
        case (st)
            ST_ABSENT, ST_INV: perm = PM_NONE;
            ST_SHR, ST_EXC:    perm = PM_RD;
            ST_MOD:            perm = PM_RW;
            default:           perm = PM_BUSY;
        endcase
    end
endmodule

// File: rtl/coh_line_next.sv
// Module: transition table of the line; combinational next state and actions.
// Assumes the caller applies the result only when an event is accepted.
module coh_line_next
    import coh_line_pkg::*;
(
    input  line_st_e   st,
    input  logic [3:0] kind,
    input  logic       from_l1,
    input  logic       settle,
    output line_st_e   nxt,
    output step_t      act
);
    evt_e ev;
    logic bad;
    logic proc_ev;

    // decode the event and pick the transition
    always_comb begin
        ev      = evt_e'(kind);
        proc_ev = (ev == EV_LOAD) || (ev == EV_FETCH) ||
                  (ev == EV_STORE) || (ev == EV_EVICT);
        act     = '0;
        nxt     = st;
        bad     = 1'b0;
        case (st)
            ST_ABSENT, ST_INV: begin
                case (ev)
                    EV_LOAD:  begin act.strb[SB_GETS] = 1'b1; act.clr_cnt = 1'b1; nxt = ST_WAIT_S; end
                    EV_FETCH: begin act.strb[SB_GETI] = 1'b1; act.clr_cnt = 1'b1; nxt = ST_WAIT_S; end
                    EV_STORE: begin act.strb[SB_GETX] = 1'b1; act.clr_cnt = 1'b1; nxt = ST_WAIT_M; end
                    EV_EVICT: nxt = ST_ABSENT;
                    EV_INVAL: act.strb[SB_IACK] = 1'b1;
                    default:  bad = 1'b1;
                endcase
            end
            ST_SHR: begin
                case (ev)
                    EV_LOAD, EV_FETCH: act.strb[SB_LHIT] = 1'b1;
                    EV_STORE: begin act.strb[SB_UPG] = 1'b1; act.clr_cnt = 1'b1; nxt = ST_UPG; end
                    EV_EVICT: nxt = ST_INV;
                    EV_INVAL: begin act.strb[SB_IACK] = 1'b1; nxt = ST_INV; end
                    default:  bad = 1'b1;
                endcase
            end
            ST_EXC, ST_MOD: begin
                case (ev)
                    EV_LOAD, EV_FETCH: act.strb[SB_LHIT] = 1'b1;
                    EV_STORE: begin act.strb[SB_SHIT] = 1'b1; nxt = ST_MOD; end
                    EV_EVICT: begin
                        act.strb[SB_PUTX] = 1'b1;
                        nxt = (st == ST_MOD) ? ST_WB_MOD : ST_WB_EXC;
                    end
                    EV_INVAL: begin
                        if (st == ST_MOD) act.strb[SB_DL2]  = 1'b1;
                        else              act.strb[SB_IACK] = 1'b1;
                        nxt = ST_INV;
                    end
                    EV_FWD_EXCL: begin act.strb[SB_DREQ] = 1'b1; nxt = ST_INV; end
                    EV_FWD_RD, EV_FWD_FETCH: begin
                        act.strb[SB_DREQ] = 1'b1;
                        act.strb[SB_DL2]  = 1'b1;
                        nxt = ST_SHR;
                    end
                    default: bad = 1'b1;
                endcase
            end
            ST_WAIT_S, ST_WAIT_S_KILL: begin
                if (proc_ev) act.strb[SB_RCY] = 1'b1;
                else begin
                    case (ev)
                        EV_INVAL: begin act.strb[SB_IACK] = 1'b1; nxt = ST_WAIT_S_KILL; end
                        EV_DATA: begin
                            if (from_l1 || settle) begin
                                act.strb[SB_LHIT] = 1'b1;
                                act.strb[SB_UNB]  = from_l1;
                                act.upd_cnt       = 1'b1;
                                nxt = (st == ST_WAIT_S) ? ST_SHR : ST_INV;
                            end else bad = 1'b1;
                        end
                        EV_DATA_EXCL: begin
                            act.strb[SB_LHIT] = 1'b1;
                            act.strb[SB_XUNB] = 1'b1;
                            nxt = ST_EXC;
                        end
                        default: bad = 1'b1;
                    endcase
                end
            end
            ST_WAIT_M, ST_UPG: begin
                if (proc_ev) act.strb[SB_RCY] = 1'b1;
                else begin
                    case (ev)
                        EV_INVAL: begin act.strb[SB_IACK] = 1'b1; nxt = ST_WAIT_M; end
                        EV_DATA: begin
                            if (st != ST_WAIT_M) bad = 1'b1;
                            else begin
                                act.upd_cnt = 1'b1;
                                if (settle) begin
                                    act.strb[SB_SHIT] = 1'b1;
                                    act.strb[SB_XUNB] = 1'b1;
                                    nxt = ST_MOD;
                                end else nxt = ST_UPG;
                            end
                        end
                        EV_ACK: begin
                            if (settle && st == ST_WAIT_M) bad = 1'b1;
                            else begin
                                act.upd_cnt = 1'b1;
                                if (settle) begin
                                    act.strb[SB_SHIT] = 1'b1;
                                    act.strb[SB_XUNB] = 1'b1;
                                    nxt = ST_MOD;
                                end
                            end
                        end
                        default: bad = 1'b1;
                    endcase
                end
            end
            ST_WB_MOD, ST_WB_EXC: begin
                if (proc_ev) act.strb[SB_RCY] = 1'b1;
                else begin
                    case (ev)
                        EV_INVAL: begin
                            if (st == ST_WB_MOD) act.strb[SB_DL2]  = 1'b1;
                            else                 act.strb[SB_IACK] = 1'b1;
                            nxt = ST_DRAIN;
                        end
                        EV_FWD_EXCL: begin act.strb[SB_DREQ] = 1'b1; nxt = ST_DRAIN; end
                        EV_FWD_RD, EV_FWD_FETCH: begin
                            act.strb[SB_DREQ] = 1'b1;
                            act.strb[SB_DL2]  = 1'b1;
                            nxt = ST_DRAIN;
                        end
                        EV_WB_ACK: nxt = ST_INV;
                        default:   bad = 1'b1;
                    endcase
                end
            end
            ST_DRAIN: begin
                if (proc_ev) act.strb[SB_RCY] = 1'b1;
                else begin
                    case (ev)
                        EV_INVAL:  act.strb[SB_IACK] = 1'b1;
                        EV_WB_ACK: nxt = ST_INV;
                        default:   bad = 1'b1;
                    endcase
                end
            end
            default: bad = 1'b1;
        endcase
        if (bad) begin
            act     = '0;
            act.err = 1'b1;
            nxt     = st;
        end
    end
endmodule

// File: rtl/l1_line_coh_ctrl.sv
// Module: top of the per-line coherence controller; registers state, strobes
// and the sticky error. Assumes at most one event per clock, held for one cycle.
module l1_line_coh_ctrl
    import coh_line_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_valid,
    input  logic [3:0]              evt_kind,
    input  logic                    evt_from_l1,
    input  logic signed [CNT_W-1:0] evt_cnt,
    output logic [3:0]              line_state,
    output logic [1:0]              line_perm,
    output logic                    req_gets,
    output logic                    req_geti,
    output logic                    req_getx,
    output logic                    req_upgrade,
    output logic                    req_putx,
    output logic                    rsp_data_req,
    output logic                    rsp_data_l2,
    output logic                    rsp_inv_ack,
    output logic                    unblk_shared,
    output logic                    unblk_excl,
    output logic                    load_hit,
    output logic                    store_hit,
    output logic                    recycle,
    output logic                    proto_err
);
    line_st_e         st_q;
    line_st_e         st_d;
    step_t            act_c;
    logic             settle;
    logic [NSTRB-1:0] strb_q;
    logic             err_q;
    perm_e            perm;

    coh_ack_tracker #(.CNT_W(CNT_W)) u_acks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (evt_valid & act_c.clr_cnt),
        .upd    (evt_valid & act_c.upd_cnt),
        .cnt    (evt_cnt),
        .settle (settle)
    );

    coh_line_next u_next (
        .st      (st_q),
        .kind    (evt_kind),
        .from_l1 (evt_from_l1),
        .settle  (settle),
        .nxt     (st_d),
        .act     (act_c)
    );

    coh_perm_map u_perm (
        .st   (st_q),
        .perm (perm)
    );

    // state, strobe and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_ABSENT;
            strb_q <= '0;
            err_q  <= 1'b0;
        end else if (evt_valid) begin
            st_q   <= st_d;
            strb_q <= act_c.strb;
            err_q  <= err_q | act_c.err;
        end else begin
            strb_q <= '0;
        end
    end

    // port mapping
    always_comb begin
        line_state   = st_q;
        line_perm    = perm;
        req_gets     = strb_q[SB_GETS];
        req_geti     = strb_q[SB_GETI];
        req_getx     = strb_q[SB_GETX];
        req_upgrade  = strb_q[SB_UPG];
        req_putx     = strb_q[SB_PUTX];
        rsp_data_req = strb_q[SB_DREQ];
        rsp_data_l2  = strb_q[SB_DL2];
        rsp_inv_ack  = strb_q[SB_IACK];
        unblk_shared = strb_q[SB_UNB];
        unblk_excl   = strb_q[SB_XUNB];
        load_hit     = strb_q[SB_LHIT];
        store_hit    = strb_q[SB_SHIT];
        recycle      = strb_q[SB_RCY];
        proto_err    = err_q;
    end

    p_one_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_gets, req_geti, req_getx, req_upgrade, req_putx}));

    p_putx_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_putx |-> (line_state == ST_WB_MOD || line_state == ST_WB_EXC));

    p_xunblock_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unblk_excl |-> (line_state == ST_EXC || line_state == ST_MOD));

    p_store_hit_rw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        store_hit |-> (line_perm == PM_RW));

    p_recycle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recycle |-> (line_state == $past(line_state)) &&
                    ($countones(strb_q) == 1));

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_err_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> (line_state == $past(line_state)) && (strb_q == '0));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> (strb_q == '0));

endmodule

// File: tb/sim_l1_line_coh_ctrl.sv
`timescale 1ns/1ps
module sim_l1_line_coh_ctrl;
    localparam int W = 6;
    // strobe mask bits: gets geti getx upg putx dreq dl2 iack unb xunb lhit shit rcy
    localparam logic [12:0] M_GETS = 13'h1000, M_GETI = 13'h0800, M_GETX = 13'h0400,
        M_UPG = 13'h0200, M_PUTX = 13'h0100, M_DREQ = 13'h0080, M_DL2 = 13'h0040,
        M_IACK = 13'h0020, M_UNB = 13'h0010, M_XUNB = 13'h0008, M_LHIT = 13'h0004,
        M_SHIT = 13'h0002, M_RCY = 13'h0001, M_NONE = 13'h0000;
    localparam logic [3:0] LD = 0, IF = 1, STO = 2, EVI = 3, INV = 4, FX = 5, FR = 6,
        FF = 7, DAT = 8, DX = 9, ACK = 10, WBA = 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, evt_valid, evt_from_l1;
    logic [3:0] evt_kind;
    logic signed [W-1:0] evt_cnt;
    logic [3:0] line_state;
    logic [1:0] line_perm;
    logic req_gets, req_geti, req_getx, req_upgrade, req_putx, rsp_data_req, rsp_data_l2;
    logic rsp_inv_ack, unblk_shared, unblk_excl, load_hit, store_hit, recycle, proto_err;
    int total = 0;
    int bad = 0;

    l1_line_coh_ctrl #(.CNT_W(W)) u0 (.*);

    function automatic logic [12:0] strobes();
        return {req_gets, req_geti, req_getx, req_upgrade, req_putx, rsp_data_req,
                rsp_data_l2, rsp_inv_ack, unblk_shared, unblk_excl, load_hit,
                store_hit, recycle};
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt_valid = 1'b0; evt_kind = '0; evt_from_l1 = 1'b0; evt_cnt = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one event for one edge, then check state and strobes
    task automatic step(input logic [3:0] k, input logic fl, input int c,
                        input int es, input logic [12:0] em, input string tag);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_from_l1 = fl; evt_cnt = c[W-1:0];
        @(negedge clk);
        evt_valid = 1'b0; evt_from_l1 = 1'b0; evt_cnt = '0;
        chk({tag, " state"}, int'(line_state), es);
        chk({tag, " strobes"}, int'(strobes()), int'(em));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 state", int'(line_state), 0);
        chk("R1 perm", int'(line_perm), 0);
        chk("R1 strobes", int'(strobes()), 0);
        chk("R1 err", int'(proto_err), 0);
    endtask

    task automatic t_idle();
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load miss");
        chk("R2 busy perm", int'(line_perm), 3);
        do_reset();
        step(IF, 0, 0, 5, M_GETI, "R3 fetch miss");
        do_reset();
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        do_reset();
        step(INV, 0, 0, 0, M_IACK, "R3 inval absent");
        step(EVI, 0, 0, 0, M_NONE, "R3 evict absent");
    endtask

    task automatic t_shared_upgrade();
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DAT, 0, 0, 2, M_LHIT, "R9 data to shared");
        chk("R2 shared perm", int'(line_perm), 1);
        step(LD, 0, 0, 2, M_LHIT, "R4 shared hit");
        step(STO, 0, 0, 7, M_UPG, "R4 upgrade");
        step(LD, 0, 0, 7, M_RCY, "R8 recycle upgrading");
        step(ACK, 0, 0, 4, M_SHIT | M_XUNB, "R10 upgrade done");
        chk("R2 modified perm", int'(line_perm), 2);
        step(STO, 0, 0, 4, M_SHIT, "R4 modified store");
        step(EVI, 0, 0, 9, M_PUTX, "R6 evict modified");
        step(WBA, 0, 0, 1, M_NONE, "R6 wb ack");
        chk("R2 invalid perm", int'(line_perm), 0);
        step(IF, 0, 0, 5, M_GETI, "R3 fetch from invalid");
        step(DAT, 0, 0, 2, M_LHIT, "R9 fetch data");
        step(EVI, 0, 0, 1, M_NONE, "R4 silent shared evict");
    endtask

    task automatic t_exclusive();
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DX, 0, 0, 3, M_LHIT | M_XUNB, "R9 exclusive data");
        chk("R2 exclusive perm", int'(line_perm), 1);
        step(STO, 0, 0, 4, M_SHIT, "R4 silent E to M");
        step(FR, 0, 0, 2, M_DREQ | M_DL2, "R5 fwd read");
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DX, 0, 0, 3, M_LHIT | M_XUNB, "R9 exclusive data");
        step(FX, 0, 0, 1, M_DREQ, "R5 fwd excl");
        step(LD, 0, 0, 5, M_GETS, "R3 reload");
        step(DX, 0, 0, 3, M_LHIT | M_XUNB, "R9 exclusive data");
        step(INV, 0, 0, 1, M_IACK, "R5 inval exclusive");
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(DAT, 0, 0, 4, M_SHIT | M_XUNB, "R10 data no acks");
        step(INV, 0, 0, 1, M_DL2, "R5 inval modified");
    endtask

    task automatic t_writeback_race();
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DX, 0, 0, 3, M_LHIT | M_XUNB, "R9 exclusive data");
        step(EVI, 0, 0, 10, M_PUTX, "R6 evict exclusive");
        step(STO, 0, 0, 10, M_RCY, "R8 recycle writeback");
        step(INV, 0, 0, 11, M_IACK, "R7 inval wb exclusive");
        step(INV, 0, 0, 11, M_IACK, "R7 inval drain");
        step(EVI, 0, 0, 11, M_RCY, "R8 recycle drain");
        step(WBA, 0, 0, 1, M_NONE, "R7 drain wb ack");
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(DAT, 0, 0, 4, M_SHIT | M_XUNB, "R10 data no acks");
        step(EVI, 0, 0, 9, M_PUTX, "R6 evict modified");
        step(FF, 0, 0, 11, M_DREQ | M_DL2, "R7 fwd fetch in wb");
        step(WBA, 0, 0, 1, M_NONE, "R7 drain wb ack");
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(DAT, 0, 0, 4, M_SHIT | M_XUNB, "R10 data no acks");
        step(EVI, 0, 0, 9, M_PUTX, "R6 evict modified");
        step(INV, 0, 0, 11, M_DL2, "R7 inval wb modified");
        do_reset();
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(DAT, 0, 0, 4, M_SHIT | M_XUNB, "R10 data no acks");
        step(EVI, 0, 0, 9, M_PUTX, "R6 evict modified");
        step(FX, 0, 0, 11, M_DREQ, "R7 fwd excl in wb");
    endtask

    task automatic t_read_race();
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(INV, 0, 0, 8, M_IACK, "R9 inval before data");
        step(IF, 0, 0, 8, M_RCY, "R8 recycle killed");
        step(DAT, 0, 0, 1, M_LHIT, "R9 killed data");
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DAT, 1, 3, 2, M_LHIT | M_UNB, "R9 peer data");
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(INV, 0, 0, 8, M_IACK, "R9 inval before data");
        step(DAT, 1, 0, 1, M_LHIT | M_UNB, "R9 killed peer data");
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(INV, 0, 0, 8, M_IACK, "R9 inval before data");
        step(DX, 0, 0, 3, M_LHIT | M_XUNB, "R9 killed excl data");
    endtask

    task automatic t_ack_count();
        do_reset();
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(ACK, 0, 1, 6, M_NONE, "R10 early ack");
        step(DAT, 0, -2, 7, M_NONE, "R10 data owes one");
        step(ACK, 0, 1, 4, M_SHIT | M_XUNB, "R10 last ack");
        do_reset();
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(DAT, 0, -1, 7, M_NONE, "R10 data owes one");
        step(INV, 0, 0, 6, M_IACK, "R11 inval upgrading");
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DAT, 0, 0, 2, M_LHIT, "R9 data");
        step(STO, 0, 0, 7, M_UPG, "R4 upgrade");
        step(INV, 0, 0, 6, M_IACK, "R11 inval during upgrade");
        step(DAT, 0, 0, 4, M_SHIT | M_XUNB, "R11 data after inval");
    endtask

    task automatic t_errors();
        do_reset();
        step(WBA, 0, 0, 0, M_NONE, "R12 stray wb ack");
        chk("R12 err set", int'(proto_err), 1);
        step(LD, 0, 0, 5, M_GETS, "R12 still works");
        chk("R12 err sticky", int'(proto_err), 1);
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R3 load");
        step(DAT, 0, -1, 5, M_NONE, "R12 unsettled read data");
        chk("R12 err read data", int'(proto_err), 1);
        do_reset();
        step(4'd13, 0, 0, 0, M_NONE, "R12 bad code");
        chk("R12 err code", int'(proto_err), 1);
        do_reset();
        step(STO, 0, 0, 6, M_GETX, "R3 store miss");
        step(ACK, 0, 0, 6, M_NONE, "R12 settling ack before data");
        chk("R12 err ack", int'(proto_err), 1);
    endtask

    task automatic t_pulse();
        do_reset();
        step(LD, 0, 0, 5, M_GETS, "R13 pulse");
        @(negedge clk);
        chk("R13 pulse gone", int'(strobes()), 0);
        chk("R13 state held", int'(line_state), 5);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_shared_upgrade();
        t_exclusive();
        t_writeback_race();
        t_read_race();
        t_ack_count();
        t_errors();
        t_pulse();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL R13 watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule